// File: doc/BRIEF.md
# Receiver CDR Fast Recovery Controller

This block sits beside the clock-data recovery (CDR) circuit of one receive lane. It decides, cycle by cycle, whether the CDR should track the local reference clock or the incoming bit stream. An automatic lock sequence waits for a frequency check, which is too slow when a PCIe-style link leaves its standby power state. This controller instead switches the CDR from protocol events. An electrical idle ordered set seen in the active state sends the CDR back to the reference clock. Once the analog signal-detect flag has been stable for a programmable run of cycles and a fast training sequence strobe has arrived, the controller hands the CDR over to the data.

In automatic mode the controller needs no user input. When the enable input is low, the two lock controls are taken from manual inputs, with lock-to-reference winning if both manual inputs are high. Both outputs are registered. With a 16-cycle default run, the switch to data takes well under the microsecond-scale fast-training budget.

Top module: `cdr_fast_recovery`

## Requirements
- R1: After a synchronous reset, lock_ref is 1 and lock_data is 0.
- R2: lock_ref and lock_data are never both 1 in the same cycle. While auto_en was 1 at the previous clock edge, exactly one of them is 1.
- R3: While locked to reference, once an fts_stb pulse has been sampled and sig_det has been sampled high on DET_CYCLES (default 16) consecutive edges, lock_data rises and lock_ref falls on the next edge at which sig_det is still high.
- R4: Without any fts_stb pulse, the block stays locked to reference however long sig_det stays high.
- R5: A single cycle with sig_det low while locked to reference restarts the count of consecutive sig_det cycles from zero.
- R6: While locked to data in automatic mode, sig_det sampled low returns the block to lock-to-reference at that same clock edge.
- R7: While locked to data, an eios_stb sampled with pwr_state equal to 2'b00 (active state) returns the block to lock-to-reference at that clock edge.
- R8: An eios_stb sampled with pwr_state other than 2'b00 has no effect on the lock mode.
- R9: An eios_stb in the active state while locked to reference discards any fts_stb seen so far and restarts the sig_det count.
- R10: With auto_en low, each edge loads lock_ref from man_ref and lock_data from man_data AND NOT man_ref.
- R11: When auto_en returns high, the block starts locked to reference and needs a full qualification (R3) before it locks to data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_en | input | 1 | 1 selects automatic control, 0 selects the manual inputs |
| sig_det | input | 1 | Signal-detect flag from the receiver input buffer |
| eios_stb | input | 1 | One-cycle strobe: an electrical idle ordered set was decoded |
| fts_stb | input | 1 | One-cycle strobe: a fast training sequence set was decoded |
| pwr_state | input | 2 | Current power state; 2'b00 is the active state |
| man_ref | input | 1 | Manual lock-to-reference request |
| man_data | input | 1 | Manual lock-to-data request |
| lock_ref | output | 1 | Force CDR to lock to the reference clock |
| lock_data | output | 1 | Force CDR to lock to incoming data |

## Verification
The hardest situation to reach is the boundary of the qualification window. The outputs must stay unchanged after exactly DET_CYCLES sampled sig_det cycles and flip on the following edge. That result holds only if an fts_stb was captured earlier and no eios_stb cleared it in between. The bench reaches this state with a fixed sequence: it sends one fts_stb while sig_det is low, then raises sig_det and samples at each edge count around the limit. Variants of the same sequence break it in a controlled way: a one-cycle sig_det dropout, a missing strobe, or an active-state eios_stb. In each variant the bench checks that the switch moves later or never happens.

// File: rtl/cdr_fr_pkg.sv
package cdr_fr_pkg;
  typedef enum logic [0:0] {
    LK_REF  = 1'b0,
    LK_DATA = 1'b1
  } lock_mode_e;

  localparam logic [1:0] PWR_ACTIVE = 2'b00;
endpackage

// File: rtl/cdr_fr_qual.sv
module cdr_fr_qual #(
  parameter int DET_CYCLES = 16,
  localparam int CW = $clog2(DET_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic sig_det,
  input  logic fts_stb,
  output logic ready
);
  logic [CW-1:0] run_q;
  logic          fts_seen_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      run_q      <= '0;
      fts_seen_q <= 1'b0;
    end else begin
      if (!sig_det) run_q <= '0;
      else if (run_q != CW'(DET_CYCLES)) run_q <= run_q + 1'b1;
      if (fts_stb) fts_seen_q <= 1'b1;
    end
  end

  assign ready = (run_q == CW'(DET_CYCLES)) && fts_seen_q;
endmodule

// File: rtl/cdr_fr_fsm.sv
module cdr_fr_fsm
  import cdr_fr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       auto_en,
  input  logic       sig_det,
  input  logic       eios_stb,
  input  logic [1:0] pwr_state,
  input  logic       ready,
  output lock_mode_e mode_q,
  output lock_mode_e mode_d,
  output logic       qual_clear
);
  logic idle_in_active;
  assign idle_in_active = eios_stb && (pwr_state == PWR_ACTIVE);

  always_comb begin
    mode_d = mode_q;
    if (!auto_en) begin
      mode_d = LK_REF;
    end else begin
      unique case (mode_q)
        LK_REF:  if (sig_det && ready && !idle_in_active) mode_d = LK_DATA;
        LK_DATA: if (!sig_det || idle_in_active) mode_d = LK_REF;
        default: mode_d = LK_REF;
      endcase
    end
  end

  assign qual_clear = !auto_en || (mode_q != LK_REF) || idle_in_active;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= LK_REF;
    else     mode_q <= mode_d;
  end
endmodule

// File: rtl/cdr_fr_outreg.sv
module cdr_fr_outreg
  import cdr_fr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       auto_en,
  input  lock_mode_e mode_d,
  input  logic       man_ref,
  input  logic       man_data,
  output logic       lock_ref,
  output logic       lock_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_ref  <= 1'b1;
      lock_data <= 1'b0;
    end else if (!auto_en) begin
      lock_ref  <= man_ref;
      lock_data <= man_data && !man_ref;
    end else begin
      lock_ref  <= (mode_d == LK_REF);
      lock_data <= (mode_d == LK_DATA);
    end
  end
endmodule

// File: rtl/cdr_fast_recovery.sv
module cdr_fast_recovery
  import cdr_fr_pkg::*;
#(
  parameter int DET_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       auto_en,
  input  logic       sig_det,
  input  logic       eios_stb,
  input  logic       fts_stb,
  input  logic [1:0] pwr_state,
  input  logic       man_ref,
  input  logic       man_data,
  output logic       lock_ref,
  output logic       lock_data
);
  logic       ready;
  logic       qual_clear;
  lock_mode_e mode_q;
  lock_mode_e mode_d;

  cdr_fr_qual #(.DET_CYCLES(DET_CYCLES)) u_qual (
    .clk     (clk),
    .rst     (rst),
    .clear   (qual_clear),
    .sig_det (sig_det),
    .fts_stb (fts_stb),
    .ready   (ready)
  );

  cdr_fr_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .auto_en    (auto_en),
    .sig_det    (sig_det),
    .eios_stb   (eios_stb),
    .pwr_state  (pwr_state),
    .ready      (ready),
    .mode_q     (mode_q),
    .mode_d     (mode_d),
    .qual_clear (qual_clear)
  );

  cdr_fr_outreg u_out (
    .clk       (clk),
    .rst       (rst),
    .auto_en   (auto_en),
    .mode_d    (mode_d),
    .man_ref   (man_ref),
    .man_data  (man_data),
    .lock_ref  (lock_ref),
    .lock_data (lock_data)
  );
endmodule

// File: rtl/cdr_fr_checker.sv
module cdr_fr_checker #(
  parameter int DET_CYCLES = 16,
  localparam int RW = $clog2(DET_CYCLES + 2)
) (
  input logic       clk,
  input logic       rst,
  input logic       auto_en,
  input logic       sig_det,
  input logic       eios_stb,
  input logic [1:0] pwr_state,
  input logic       man_ref,
  input logic       man_data,
  input logic       lock_ref,
  input logic       lock_data
);
  logic          auto_q;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    auto_q <= auto_en;
    if (rst || !sig_det) run_q <= '0;
    else if (run_q != RW'(DET_CYCLES + 1)) run_q <= run_q + 1'b1;
  end

  always_comb begin
    if (!rst) AST_NEVER_BOTH: assert (!(lock_ref && lock_data)); // R2
  end

  AST_ONE_HOT_AUTO: assert property (@(posedge clk) disable iff (rst)
    auto_q |-> (lock_ref ^ lock_data)); // R2

  AST_EARLY_DATA: assert property (@(posedge clk) disable iff (rst)
    (auto_q && $rose(lock_data)) |-> (run_q > RW'(DET_CYCLES))); // R3

  AST_SIGLOSS_DROP: assert property (@(posedge clk) disable iff (rst)
    (lock_data && auto_en && !sig_det) |=> (lock_ref && !lock_data)); // R6

  AST_IDLE_DROP: assert property (@(posedge clk) disable iff (rst)
    (lock_data && auto_en && eios_stb && pwr_state == 2'b00) |=> (lock_ref && !lock_data)); // R7

  AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !auto_en |=> (lock_ref == $past(man_ref)) && (lock_data == ($past(man_data) && !$past(man_ref)))); // R10
endmodule

bind cdr_fast_recovery cdr_fr_checker #(.DET_CYCLES(DET_CYCLES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .auto_en   (auto_en),
  .sig_det   (sig_det),
  .eios_stb  (eios_stb),
  .pwr_state (pwr_state),
  .man_ref   (man_ref),
  .man_data  (man_data),
  .lock_ref  (lock_ref),
  .lock_data (lock_data)
);

// File: tb/tb_cdr_fast_recovery.sv
module tb_cdr_fast_recovery;
  localparam int CLK_PERIOD = 10;
  localparam int DET = 16;

  logic       clk = 1'b0;
  logic       rst, auto_en, sig_det, eios_stb, fts_stb, man_ref, man_data;
  logic [1:0] pwr_state;
  logic       lock_ref, lock_data;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdr_fast_recovery #(.DET_CYCLES(DET)) dut (
    .clk(clk), .rst(rst), .auto_en(auto_en), .sig_det(sig_det),
    .eios_stb(eios_stb), .fts_stb(fts_stb), .pwr_state(pwr_state),
    .man_ref(man_ref), .man_data(man_data),
    .lock_ref(lock_ref), .lock_data(lock_data)
  );

  task automatic chk(input string req, input logic er, input logic ed);
    checks++;
    if (lock_ref !== er || lock_data !== ed) begin
      failures++;
      $display("FAIL %s: lock_ref/lock_data actual=%b%b expected=%b%b", req, lock_ref, lock_data, er, ed);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; auto_en = 1; sig_det = 0; eios_stb = 0; fts_stb = 0;
    pwr_state = 2'b01; man_ref = 0; man_data = 0;
    tick(2);
    rst = 0;
  endtask

  task automatic send_fts();
    fts_stb = 1; tick(1); fts_stb = 0;
  endtask

  // Reach lock-to-data: fts first, then DET edges of sig_det, then one more edge
  task automatic qualify(input string req);
    sig_det = 0; send_fts();
    sig_det = 1; tick(DET);
    chk(req, 1, 0);
    tick(1);
    chk(req, 0, 1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", 1, 0);
  endtask

  task automatic t_no_fts();
    do_reset();
    sig_det = 1; tick(3 * DET);
    chk("R4", 1, 0);
    sig_det = 0; tick(1);
  endtask

  task automatic t_dropout();
    do_reset();
    send_fts();
    sig_det = 1; tick(DET - 1);
    sig_det = 0; tick(1);
    sig_det = 1; tick(DET);
    chk("R5", 1, 0);
    tick(1);
    chk("R5", 0, 1);
    sig_det = 0; tick(1);
    chk("R6", 1, 0);
  endtask

  task automatic t_idle_active();
    do_reset();
    pwr_state = 2'b00;
    qualify("R3");
    eios_stb = 1; tick(1); eios_stb = 0;
    chk("R7", 1, 0);
    sig_det = 0; tick(1);
  endtask

  task automatic t_idle_other();
    do_reset();
    qualify("R3");
    pwr_state = 2'b01; eios_stb = 1; tick(1);
    pwr_state = 2'b10; tick(1);
    pwr_state = 2'b11; tick(1); eios_stb = 0;
    chk("R8", 0, 1);
    sig_det = 0; tick(1);
    chk("R6", 1, 0);
  endtask

  task automatic t_idle_clears();
    do_reset();
    pwr_state = 2'b00;
    send_fts();
    eios_stb = 1; tick(1); eios_stb = 0;
    sig_det = 1; tick(3 * DET);
    chk("R9", 1, 0);
    send_fts();
    tick(1);
    chk("R9", 0, 1);
    sig_det = 0; tick(1);
  endtask

  task automatic t_manual();
    do_reset();
    auto_en = 0; man_ref = 0; man_data = 1; tick(1);
    chk("R10", 0, 1);
    man_ref = 1; man_data = 1; tick(1);
    chk("R10", 1, 0);
    man_ref = 0; man_data = 0; tick(1);
    chk("R10", 0, 0);
    man_data = 1; sig_det = 1; send_fts(); tick(DET);
    auto_en = 1; tick(1);
    chk("R11", 1, 0);
    tick(DET - 1);
    chk("R11", 1, 0);
    send_fts(); tick(1);
    chk("R11", 0, 1);
    sig_det = 0; tick(1);
    chk("R2", 1, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_no_fts();
        t_dropout();
        t_idle_active();
        t_idle_other();
        t_idle_clears();
        t_manual();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; failures++;
          $display("FAIL watchdog: actual=timeout expected=completion");
        end
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule